// File: doc/BRIEF.md
# Shuffled-Pairing Stochastic Bundle Multiplier

This block multiplies two numbers carried as parallel stochastic bundles. A bundle is a group of N wires in which each wire is one with probability x, and x in [0,1] is recovered as the fraction of wires that are one. Each output wire is formed by taking one wire of operand A and one wire of operand B and ANDing them. The output density therefore approximates the product of the two input densities. Operand wires are not paired index to index. Output wire k uses A wire k together with B wire `perm[k]`, where `perm` is a permutation of the B indices.

The permutation is rebuilt on request. A 16-bit LFSR is loaded from a seed and drives an in-place Fisher-Yates shuffle that takes N cycles. While the shuffle runs, no new operands are accepted. The registered output keeps its last value and is marked not valid. A build-time option complements every output wire, which turns the AND into a NAND and reproduces the polarity flip of a crossbar path. Alongside the result bundle, the block gives the number of ones in it.

Operands enter on a valid/ready stream and results leave on one. One register stage lies between them. `in_ready` is high only when no shuffle is running or being requested, and the output register is empty or being drained in the same cycle. If `out_valid` is high and `out_ready` is low, the result is held unchanged and input is stalled.

Top module: `shuffled_and_mult`

## Requirements
- R1: After reset, `busy` and `out_valid` are 0 and `in_ready` is 1. The pairing is the identity, so output wire k equals `a_bundle[k] & b_bundle[k]`.
- R2: An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. On the next cycle `out_valid` is 1 and output wire k holds `a_bundle[k] & b_bundle[perm[k]]`.
- R3: After any shuffle, `perm` is a bijection. A probe with A all ones and B one-hot at wire j gives exactly one output one, and distinct j give distinct output wires.
- R4: A `shuffle_req` sampled while idle makes `busy` high for exactly N cycles, starting on the next cycle.
- R5: While `busy` is high, `in_ready` and `out_valid` are 0, and `out_bundle` keeps its previous value.
- R6: A `shuffle_req` sampled while `busy` is high is ignored. The running shuffle still ends after N cycles and gives the same permutation as an uninterrupted run with the same seed.
- R7: Two shuffles from the same seed give the same permutation.
- R8: `out_ones` equals the number of ones in `out_bundle`, which lies in 0..N.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_bundle` holds steady and `in_ready` is 0. The pending input is accepted on the edge where `out_ready` returns high.
- R10: With `INVERT_OUT`=1, each output wire is the complement of the AND pairing, and `out_ones` is N minus the AND count.
- R11: A `shuffle_req` takes priority over `in_valid`. While `shuffle_req` is high, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shuffle_req | input | 1 | Request a new permutation |
| seed | input | 16 | LFSR seed, taken with the request |
| busy | output | 1 | Permutation being rebuilt |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair can be taken |
| a_bundle | input | N | Operand A bundle |
| b_bundle | input | N | Operand B bundle |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_bundle | output | N | Result bundle (AND or NAND) |
| out_ones | output | $clog2(N+1) | Count of ones in `out_bundle` |

## Verification
The assertions assume that the consumer may drop `out_ready` at any time. They also assume that `shuffle_req` can arrive in any cycle, including while a shuffle is already running. They do not assume that the operand bundles have any statistics. All they rely on is that reset is held for at least one edge. The stimulus drives inputs only on falling edges. It deliberately raises `shuffle_req` in the middle of a shuffle and together with `in_valid`, and it stalls the output for several cycles. This exercises every hold and priority rule, while the assumptions above still hold.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic {SH_IDLE = 1'b0, SH_RUN = 1'b1} shuf_state_e;
  localparam logic [15:0] LFSR_TAPS     = 16'hB400;
  localparam logic [15:0] LFSR_FALLBACK = 16'hACE1;
endpackage

// File: rtl/sam_lfsr.sv
module sam_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = sam_pkg::LFSR_TAPS,
  parameter logic [W-1:0] ALT  = sam_pkg::LFSR_FALLBACK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       st_q <= ALT;
    else if (load)    st_q <= (seed == '0) ? ALT : seed;
    else if (step)    st_q <= st_q[0] ? ((st_q >> 1) ^ TAPS) : (st_q >> 1);
  end

  assign state = st_q;

  p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/sam_perm_shuffle.sv
module sam_perm_shuffle #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   seed,
  output logic          busy,
  output logic [N*IW-1:0] perm_flat
);
  import sam_pkg::*;
  localparam int RW = 8;
  localparam int PW = RW + IW + 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  shuf_state_e     st_q;
  logic [IW-1:0]   idx_q;
  logic [IW-1:0]   perm_q [N];
  logic [15:0]     rnd;
  logic [PW-1:0]   prod;
  logic [IW-1:0]   pick;

  assign busy = (st_q == SH_RUN);

  sam_lfsr #(.W(16)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(start), .seed(seed),
    .step(busy), .state(rnd)
  );

  // scale a random byte into 0..idx
  assign prod = PW'(rnd[15:8]) * (PW'(idx_q) + PW'(1));
  assign pick = prod[RW +: IW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      idx_q <= '0;
      for (int i = 0; i < N; i++) perm_q[i] <= IW'(i);
    end else begin
      case (st_q)
        SH_IDLE: if (start) begin
          st_q  <= SH_RUN;
          idx_q <= LAST;
          for (int i = 0; i < N; i++) perm_q[i] <= IW'(i);
        end
        SH_RUN: begin
          if (idx_q == '0) begin
            st_q <= SH_IDLE;
          end else begin
            perm_q[idx_q] <= perm_q[pick];
            perm_q[pick]  <= perm_q[idx_q];
            idx_q         <= idx_q - 1'b1;
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_flat
    assign perm_flat[k*IW +: IW] = perm_q[k];
  end

  // busy window length check
  logic [IW:0] run_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < (IW+1)'(N)));
  p_pick_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pick <= idx_q));
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx_q != '0) |=> busy);
endmodule

// File: rtl/sam_popcount.sv
module sam_popcount #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + CW'(vec[i]);
  end
endmodule

// File: rtl/shuffled_and_mult.sv
module shuffled_and_mult #(
  parameter int N          = 16,
  parameter bit INVERT_OUT = 1'b0,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shuffle_req,
  input  logic [15:0]   seed,
  output logic          busy,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  a_bundle,
  input  logic [N-1:0]  b_bundle,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N-1:0]  out_bundle,
  output logic [CW-1:0] out_ones
);
  logic [N*IW-1:0] perm_flat;
  logic [N-1:0]    paired;
  logic [N-1:0]    result;
  logic            start;
  logic            accept;

  assign start = shuffle_req && !busy;

  sam_perm_shuffle #(.N(N), .IW(IW)) u_shuf (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .busy(busy), .perm_flat(perm_flat)
  );

  for (genvar k = 0; k < N; k++) begin : g_pair
    assign paired[k] = a_bundle[k] & b_bundle[perm_flat[k*IW +: IW]];
  end

  if (INVERT_OUT) begin : g_inv
    assign result = ~paired;
  end else begin : g_pass
    assign result = paired;
  end

  assign in_ready = !busy && !shuffle_req && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_bundle <= '0;
    end else if (start) begin
      out_valid  <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_bundle <= result;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  sam_popcount #(.N(N), .CW(CW)) u_cnt (.vec(out_bundle), .ones(out_ones));

  p_busy_blocks_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!in_ready && !out_valid));
  p_busy_holds_bundle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(out_bundle));
  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !shuffle_req) |=> (out_valid && $stable(out_bundle)));
  p_req_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    shuffle_req |-> !in_ready);
  p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ones <= CW'(N));
  p_accept_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: tb/tb_shuffled_and_mult.sv
module tb_shuffled_and_mult;
  localparam int N  = 16;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shuffle_req = 1'b0;
  logic [15:0] seed = '0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [N-1:0] a_bundle = '0, b_bundle = '0;
  logic busy, in_ready, out_valid, busy_i, in_ready_i, out_valid_i;
  logic [N-1:0] out_bundle, out_bundle_i;
  logic [CW-1:0] out_ones, out_ones_i;

  int errors = 0, checks = 0;
  int p [N];
  int p_ref [N];
  bit done = 0;

  always #4 clk = ~clk;

  shuffled_and_mult #(.N(N), .INVERT_OUT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .shuffle_req(shuffle_req), .seed(seed), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .a_bundle(a_bundle), .b_bundle(b_bundle),
    .out_valid(out_valid), .out_ready(out_ready), .out_bundle(out_bundle), .out_ones(out_ones));

  shuffled_and_mult #(.N(N), .INVERT_OUT(1'b1)) dut_inv (
    .clk(clk), .rst_n(rst_n), .shuffle_req(shuffle_req), .seed(seed), .busy(busy_i),
    .in_valid(in_valid), .in_ready(in_ready_i), .a_bundle(a_bundle), .b_bundle(b_bundle),
    .out_valid(out_valid_i), .out_ready(out_ready), .out_bundle(out_bundle_i), .out_ones(out_ones_i));

  function automatic int ones16(logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [N-1:0] model(logic [N-1:0] a, logic [N-1:0] b);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = a[k] & b[p[k]];
    return r;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one transfer with drained output; returns the registered result
  task automatic xfer(logic [N-1:0] a, logic [N-1:0] b, output logic [N-1:0] got);
    @(negedge clk);
    a_bundle = a; b_bundle = b; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    got = out_bundle;
  endtask

  task automatic t_reset;
    logic [N-1:0] got;
    check(busy == 0 && out_valid == 0 && in_ready == 1, "R1 reset flags",
          {busy, out_valid, in_ready}, 3'b001);
    for (int k = 0; k < N; k++) p[k] = k;
    xfer(16'hF0F0, 16'hCCCC, got);
    check(got == (16'hF0F0 & 16'hCCCC), "R1 identity pairing", got, 16'hC0C0);
  endtask

  task automatic t_data(string tag, int reps);
    logic [N-1:0] a, b, got, exp;
    for (int r = 0; r < reps; r++) begin
      a = N'($urandom); b = N'($urandom);
      if (r == 0) begin a = '1; b = '1; end
      if (r == 1) begin a = '0; b = '1; end
      exp = model(a, b);
      xfer(a, b, got);
      check(out_valid == 1 && got == exp, {tag, " R2 pairing"}, got, exp);
      check(int'(out_ones) == ones16(exp), {tag, " R8 count"}, out_ones, ones16(exp));
      check(out_bundle_i == ~exp && int'(out_ones_i) == N - ones16(exp),
            {tag, " R10 inverted"}, out_bundle_i, ~exp);
    end
  endtask

  // rebuild permutation; optionally re-request mid-shuffle
  task automatic t_shuffle(logic [15:0] s, bit rerequest);
    int cyc = 0;
    bit bad = 0;
    logic [N-1:0] held;
    @(negedge clk);
    held = out_bundle;
    shuffle_req = 1'b1; seed = s; in_valid = 1'b1;
    a_bundle = '1; b_bundle = '1;
    #1;
    check(in_ready == 0, "R11 request beats input", in_ready, 0);
    @(posedge clk);
    @(negedge clk);
    shuffle_req = 1'b0; in_valid = 1'b0;
    while (busy && cyc < 4 * N) begin
      shuffle_req = rerequest && (cyc == 2);
      if (in_ready || out_valid || out_bundle != held) bad = 1;
      cyc++;
      @(negedge clk);
    end
    shuffle_req = 1'b0;
    check(cyc == N, rerequest ? "R6 busy length with extra request" : "R4 busy length", cyc, N);
    check(!bad, "R5 outputs frozen while busy", bad, 0);
  endtask

  task automatic t_probe(string tag);
    logic [N-1:0] got, seen;
    seen = '0;
    for (int j = 0; j < N; j++) begin
      xfer('1, N'(1) << j, got);
      check(ones16(got) == 1 && (got & seen) == '0, {tag, " R3 bijection"}, got, 1);
      seen |= got;
      for (int k = 0; k < N; k++) if (got[k]) p[k] = j;
    end
  endtask

  task automatic t_stall;
    logic [N-1:0] e1, e2;
    bit bad = 0;
    e1 = model(16'hA5A5, 16'h3C3C);
    e2 = model(16'h0FF0, 16'hFFFF);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; a_bundle = 16'hA5A5; b_bundle = 16'h3C3C;
    @(posedge clk);
    @(negedge clk);
    a_bundle = 16'h0FF0; b_bundle = 16'hFFFF;
    for (int c = 0; c < 3; c++) begin
      #1;
      if (in_ready || !out_valid || out_bundle != e1) bad = 1;
      @(negedge clk);
    end
    check(!bad, "R9 stall holds result", out_bundle, e1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_bundle == e2, "R9 pending input taken on release", out_bundle, e2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data("identity", 4);
    t_shuffle(16'h1234, 1'b0);
    t_probe("seed1");
    for (int k = 0; k < N; k++) p_ref[k] = p[k];
    t_data("seed1", 6);
    t_stall();
    t_shuffle(16'hBEEF, 1'b0);
    t_probe("seed2");
    t_data("seed2", 4);
    t_shuffle(16'h1234, 1'b1);
    t_probe("seed1 again");
    begin
      bit same = 1;
      for (int k = 0; k < N; k++) if (p[k] != p_ref[k]) same = 0;
      check(same, "R7 R6 same seed same permutation", same, 1);
    end
    t_shuffle(16'h0000, 1'b0);
    t_probe("zero seed");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule